// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Entry Buffer

This block receives asynchronous serial characters on a single line. An external baud tick marks each sample instant; the receiver samples the line on every tick, at sixteen ticks per bit in normal mode or eight ticks per bit in double-speed mode. While idle it waits for a high-to-low transition. That transition starts a frame and aligns the per-bit sample counter. Each bit is resolved by a majority vote over three samples at the middle of the bit. Frames carry 8 data bits, least significant bit first, then an optional parity bit and one stop bit.

Each finished character goes into a two-entry buffer together with its own parity-error and frame-error flags. The data and flag outputs always describe the oldest unread character. A read strobe removes that character. The data-available flag stays high until the buffer is empty. The speed mode and the parity settings are captured when a frame starts, so a change made during a frame does not affect that frame. Clearing the enable input stops reception at once, discards any partial frame, empties the buffer and drops the pin-ownership output.

Top module: `uart_rx_top`

## Requirements
- R1: In normal mode (`dbl_speed`=0) a frame is a low start bit, 8 data bits sent LSB first, and a stop bit, each lasting 16 ticks. The received byte appears on `rd_data` with `rx_avail`=1.
- R2: In double-speed mode (`dbl_speed`=1) each bit lasts 8 ticks, and frames are otherwise received as in R1.
- R3: A bit's value is the majority of its samples 8, 9 and 10 (4, 5 and 6 in double speed), where sample 1 is the tick that saw the start edge. A single opposing sample among the three does not change the result.
- R4: If the start bit's majority vote reads high, the frame is abandoned and no character is stored.
- R5: When parity is enabled, a parity bit follows the data. With `par_odd`=0 the data plus the parity bit must contain an even number of ones; with `par_odd`=1, an odd number. A mismatch sets the character's parity flag, shown on `par_err`.
- R6: `par_en`, `par_odd` and `dbl_speed` are captured at the start edge. Changing them during a frame changes neither that frame's length nor its parity check.
- R7: A stop bit that reads low sets the character's frame flag, shown on `frm_err`.
- R8: Each character carries its own flags. `par_err` and `frm_err` describe the head character and change only when it is read.
- R9: `rx_avail` is high while at least one character is unread. A one-cycle `rd_stb` pulse removes the head character. A read while the buffer is empty has no effect.
- R10: The buffer holds two characters. A character that completes while the buffer is full is dropped and sets `ovr_err`. `ovr_err` stays set until the next read or disable.
- R11: With `rx_en`=0, `pin_own` is 0 in the same cycle. From the next cycle the buffer is empty and no partial frame survives, so re-enabling starts from idle.
- R12: After reset, `rx_avail`, `par_err`, `frm_err` and `ovr_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable; low aborts and flushes |
| dbl_speed | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 odd parity, 0 even parity |
| sample_tick | input | 1 | One-cycle pulse per sample instant |
| rx_line | input | 1 | Serial input, idle high |
| rd_stb | input | 1 | Removes the head character |
| rd_data | output | 8 | Head character data |
| rx_avail | output | 1 | Unread character present |
| par_err | output | 1 | Parity flag of head character |
| frm_err | output | 1 | Frame flag of head character |
| ovr_err | output | 1 | Sticky overrun flag |
| pin_own | output | 1 | Receiver claims the line pin |

## Verification
The assertions assume that `sample_tick` is a single-cycle pulse and that `rd_stb` is a single-cycle pulse, never held across a buffer update. They also assume that `rx_line` changes only between ticks, so every sample sees a settled value. The stimulus keeps to this: it pulses the tick once every four clocks and sets the line value before each tick. It pulses the read strobe for exactly one clock and only between ticks. Noise is injected only as a whole-tick inversion of one of the three middle samples, which is the case the vote is designed to absorb.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W  = 8;
  localparam int OS_NORM = 16;
  localparam int OS_DBL  = 8;
  localparam int CNT_W   = $clog2(OS_NORM + 1);
  localparam int BIT_W   = $clog2(DATA_W + 4);

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_char_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic parity_bad(input logic [DATA_W-1:0] d, input logic pbit,
                                      input logic odd);
    return (^d) ^ pbit ^ odd;
  endfunction
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     dbl,
  input  logic     par_en,
  input  logic     par_odd,
  input  logic     tick,
  input  logic     line,
  output logic     push,
  output rx_char_t push_char
);
  typedef enum logic {S_IDLE, S_RECV} rx_state_e;

  rx_state_e         state;
  logic              prev;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitn;
  logic [1:0]        votes;
  logic [DATA_W-1:0] shreg;
  logic              pbit, par_l, odd_l, dbl_l;

  logic [CNT_W-1:0]  os, mid, idx;
  logic [BIT_W-1:0]  stop_pos;
  logic              bitv, start_edge;

  always_comb begin
    os         = dbl_l ? CNT_W'(OS_DBL) : CNT_W'(OS_NORM);
    mid        = os >> 1;
    idx        = (cnt == os) ? CNT_W'(1) : cnt + CNT_W'(1);
    stop_pos   = BIT_W'(DATA_W + 1) + BIT_W'(par_l);
    bitv       = maj3(votes[1], votes[0], line);
    start_edge = prev & ~line;
  end

  always_ff @(posedge clk) begin
    push <= 1'b0;
    if (!rst_n || !en) begin
      state <= S_IDLE;
      prev  <= 1'b1;
      cnt   <= '0;
      bitn  <= '0;
      votes <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
      par_l <= 1'b0;
      odd_l <= 1'b0;
      dbl_l <= 1'b0;
      push_char <= '0;
    end else if (tick) begin
      case (state)
        S_IDLE: begin
          prev <= line;
          if (start_edge) begin
            state <= S_RECV;
            cnt   <= CNT_W'(1);
            bitn  <= '0;
            par_l <= par_en;
            odd_l <= par_odd;
            dbl_l <= dbl;
          end
        end
        default: begin
          cnt <= idx;
          if (idx == CNT_W'(1)) bitn <= bitn + BIT_W'(1);
          if (idx == mid || idx == mid + CNT_W'(1)) votes <= {votes[0], line};
          if (idx == mid + CNT_W'(2)) begin
            if (bitn == '0) begin
              if (bitv) begin
                state <= S_IDLE;
                prev  <= line;
              end
            end else if (bitn <= BIT_W'(DATA_W)) begin
              shreg <= {bitv, shreg[DATA_W-1:1]};
            end else if (bitn < stop_pos) begin
              pbit <= bitv;
            end else begin
              push           <= 1'b1;
              push_char.data <= shreg;
              push_char.perr <= par_l & parity_bad(shreg, pbit, odd_l);
              push_char.ferr <= ~bitv;
              state          <= S_IDLE;
              prev           <= line;
            end
          end
        end
      endcase
    end
  end

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state == S_IDLE && !push));
  // R1
  push_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (state == S_IDLE));
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RECV) |-> (cnt >= CNT_W'(1) && cnt <= os));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flush,
  input  logic     push,
  input  rx_char_t wdata,
  input  logic     rd,
  output rx_char_t head,
  output logic     avail,
  output logic     ovr
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CT_W  = $clog2(DEPTH + 1);

  rx_char_t          mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CT_W-1:0]   count;
  logic              pop, full, acc;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    avail = (count != '0);
    full  = (count == CT_W'(DEPTH));
    pop   = rd & avail;
    acc   = push & (~full | pop);
    head  = mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovr   <= 1'b0;
    end else begin
      if (acc) wptr <= bump(wptr);
      if (pop) rptr <= bump(rptr);
      count <= count + CT_W'(acc) - CT_W'(pop);
      if (push && !acc) ovr <= 1'b1;
      else if (pop)     ovr <= 1'b0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) mem[g] <= '0;
      else if (acc && !flush && wptr == PTR_W'(g)) mem[g] <= wdata;
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CT_W'(DEPTH));
  // R10
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !rd && !flush) |=> ovr);
  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!avail && !ovr));
  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!avail && rd && !push) |=> !avail);
endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              dbl_speed,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              sample_tick,
  input  logic              rx_line,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_avail,
  output logic              par_err,
  output logic              frm_err,
  output logic              ovr_err,
  output logic              pin_own
);
  logic     char_push;
  rx_char_t char_new, char_head;

  uart_rx_sampler i_sampler (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .dbl(dbl_speed), .par_en(par_en),
    .par_odd(par_odd), .tick(sample_tick), .line(rx_line),
    .push(char_push), .push_char(char_new)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_n), .flush(~rx_en), .push(char_push), .wdata(char_new),
    .rd(rd_stb), .head(char_head), .avail(rx_avail), .ovr(ovr_err)
  );

  assign rd_data = char_head.data;
  assign par_err = rx_avail & char_head.perr;
  assign frm_err = rx_avail & char_head.ferr;
  assign pin_own = rx_en;

  // R8
  flags_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_avail |-> (!par_err && !frm_err));
endmodule

// File: tb/test_uart_rx_top.sv
`timescale 1ns/1ps
module test_uart_rx_top;
  logic clk = 0, rst_n = 0, rx_en = 0, dbl_speed = 0, par_en = 0, par_odd = 0;
  logic sample_tick = 0, rx_line = 1, rd_stb = 0;
  logic [7:0] rd_data;
  logic rx_avail, par_err, frm_err, ovr_err, pin_own;
  int total = 0, bad = 0;

  uart_rx_top i_uart_rx_top (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .dbl_speed(dbl_speed), .par_en(par_en),
    .par_odd(par_odd), .sample_tick(sample_tick), .rx_line(rx_line), .rd_stb(rd_stb),
    .rd_data(rd_data), .rx_avail(rx_avail), .par_err(par_err), .frm_err(frm_err),
    .ovr_err(ovr_err), .pin_own(pin_own)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic tick_once(input logic v);
    rx_line = v;
    sample_tick = 1; clocks(1);
    sample_tick = 0; clocks(3);
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) tick_once(1'b1);
  endtask

  // frame bits: start, 8 data LSB first, optional parity, stop; glitch_pos flips middle sample
  task automatic send_frame(input logic [7:0] d, input bit with_par, input logic pval,
                            input logic stopv, input int glitch_pos);
    int os;
    logic [10:0] bits;
    int nb;
    os = dbl_speed ? 8 : 16;
    idle_ticks(2);
    bits = '0;
    bits[8:1] = d;
    nb = 10;
    if (with_par) begin bits[9] = pval; bits[10] = stopv; nb = 11; end
    else bits[9] = stopv;
    for (int b = 0; b < nb; b++)
      for (int j = 1; j <= os; j++)
        tick_once((b == glitch_pos && j == os/2 + 1) ? ~bits[b] : bits[b]);
    idle_ticks(2);
  endtask

  task automatic read_one;
    rd_stb = 1; clocks(1); rd_stb = 0; clocks(1);
  endtask

  function automatic logic even_bit(input logic [7:0] d);
    return ^d;
  endfunction

  task automatic t_reset;
    chk("R12 avail", rx_avail, 0); chk("R12 perr", par_err, 0);
    chk("R12 ferr", frm_err, 0);   chk("R12 ovr", ovr_err, 0);
  endtask

  task automatic t_normal;
    dbl_speed = 0; send_frame(8'hA5, 0, 0, 1, -1);
    chk("R1 avail", rx_avail, 1); chk("R1 data", rd_data, 8'hA5);
    chk("R1 ferr", frm_err, 0);
    read_one; chk("R9 empty after read", rx_avail, 0);
  endtask

  task automatic t_double;
    dbl_speed = 1; send_frame(8'h3C, 0, 0, 1, -1);
    chk("R2 data", rd_data, 8'h3C); chk("R2 avail", rx_avail, 1);
    read_one;
    send_frame(8'h81, 0, 0, 1, 4);
    chk("R3 vote 8x", rd_data, 8'h81); read_one;
    dbl_speed = 0;
  endtask

  task automatic t_vote;
    send_frame(8'h5A, 0, 0, 1, 3);
    chk("R3 vote 16x", rd_data, 8'h5A); read_one;
  endtask

  task automatic t_glitch;
    idle_ticks(2);
    for (int j = 0; j < 3; j++) tick_once(1'b0);
    idle_ticks(30);
    chk("R4 glitch dropped", rx_avail, 0);
  endtask

  task automatic t_parity;
    par_en = 1; par_odd = 0;
    send_frame(8'h37, 1, even_bit(8'h37), 1, -1);
    chk("R5 even good", par_err, 0); chk("R5 even data", rd_data, 8'h37); read_one;
    send_frame(8'h37, 1, ~even_bit(8'h37), 1, -1);
    chk("R5 even bad", par_err, 1); read_one;
    par_odd = 1;
    send_frame(8'h0F, 1, ~even_bit(8'h0F), 1, -1);
    chk("R5 odd good", par_err, 0); read_one;
    send_frame(8'h0F, 1, even_bit(8'h0F), 1, -1);
    chk("R5 odd bad", par_err, 1); read_one;
    par_en = 0; par_odd = 0;
  endtask

  task automatic t_latch;
    par_en = 1;
    fork
      send_frame(8'h11, 1, 1'b1, 1, -1);
      begin clocks(8 + 40); par_en = 0; end
    join
    chk("R6 parity latched data", rd_data, 8'h11);
    chk("R6 parity latched flag", par_err, 1);
    chk("R6 frame len", frm_err, 0); read_one;
    par_en = 0;
    fork
      send_frame(8'hE2, 0, 0, 1, -1);
      begin clocks(8 + 40); par_en = 1; dbl_speed = 1; end
    join
    chk("R6 no parity latched", rd_data, 8'hE2); chk("R6 perr", par_err, 0);
    read_one; par_en = 0; dbl_speed = 0;
  endtask

  task automatic t_framing_and_flags;
    send_frame(8'h44, 0, 0, 0, -1);
    send_frame(8'h55, 0, 0, 1, -1);
    chk("R7 frame err", frm_err, 1); chk("R7 data", rd_data, 8'h44);
    read_one;
    chk("R8 next head flag", frm_err, 0); chk("R8 next head data", rd_data, 8'h55);
    read_one;
  endtask

  task automatic t_overrun;
    send_frame(8'h01, 0, 0, 1, -1);
    send_frame(8'h02, 0, 0, 1, -1);
    chk("R10 no ovr yet", ovr_err, 0);
    send_frame(8'h03, 0, 0, 1, -1);
    chk("R10 ovr set", ovr_err, 1); chk("R10 head kept", rd_data, 8'h01);
    read_one;
    chk("R10 ovr cleared", ovr_err, 0); chk("R10 second", rd_data, 8'h02);
    read_one;
    chk("R10 third dropped", rx_avail, 0);
    read_one;
    chk("R9 empty read ignored", rx_avail, 0);
    send_frame(8'h66, 0, 0, 1, -1);
    chk("R9 after empty read", rd_data, 8'h66); read_one;
  endtask

  task automatic t_disable;
    send_frame(8'h77, 0, 0, 1, -1);
    chk("R11 precondition", rx_avail, 1);
    fork
      send_frame(8'h99, 0, 0, 1, -1);
      begin
        clocks(8 + 200); rx_en = 0; #0.5;
        chk("R11 pin released", pin_own, 0);
        clocks(1); chk("R11 flushed", rx_avail, 0);
      end
    join
    rx_en = 1; idle_ticks(40);
    chk("R11 no partial", rx_avail, 0); chk("R11 pin back", pin_own, 1);
    send_frame(8'hC3, 0, 0, 1, -1);
    chk("R11 resumes", rd_data, 8'hC3); read_one;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clocks(3);
    t_reset;
    rst_n = 1; clocks(1);
    t_reset;
    rx_en = 1; clocks(1);
    t_normal;
    t_double;
    t_vote;
    t_glitch;
    t_parity;
    t_latch;
    t_framing_and_flags;
    t_overrun;
    t_disable;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule